// File: doc/BRIEF.md
# Consumer Digital Audio Interface Transmitter

This block turns a stream of stereo PCM samples into a single serial line that follows the IEC 958 consumer format. Each audio frame holds two 32-slot subframes, one for each channel. A subframe opens with a synchronisation preamble. A 24-bit audio field follows, then four flag slots: validity, user, channel status and parity. Frames are grouped into blocks of 192. The channel-status bit of each frame is one bit of a fixed 192-bit consumer word. The only live part of that word is the de-emphasis field, which follows a control input. Every slot is biphase-mark coded onto the line.

The block runs from the system clock. An internal enable fires once every `DIV_RATIO` system cycles, and each enable puts out one line half-cell. A frame is 128 half-cells, so with the defaults an 8.192 MHz clock gives a 32 kHz frame rate. The host pulses a sample strobe once per frame with a 14-bit left sample, a 14-bit right sample and a shared validity flag. These values are held and sent in the next frame that starts after the strobe. Each sample is left-justified into the 24-bit audio field.

Top module: `cdai_tx`

## Requirements
- R1: Slots 4..27 of a subframe carry the 24-bit audio word with its LSB in slot 4 and its MSB in slot 27. The 14-bit sample occupies word bits 23..10, and word bits 9..0 are zero.
- R2: Slot 31 is a parity bit that makes the number of ones across slots 4..31 even. As a result, the line is low at the first half-cell boundary of every subframe after reset.
- R3: The left subframe (sent first in a frame) uses preamble B in frame 0 of each 192-frame block and preamble M in all other frames. The right subframe always uses preamble W. The frame index counts 0..191 and then wraps.
- R4: When the line is low before a preamble, the preambles are sent as the 8 half-cells B=11101000, M=11100010 and W=11100100, leftmost first. When the line is high before a preamble, each pattern is inverted. The first preamble half-cell always differs from the level before it.
- R5: Slots 4..31 use biphase-mark coding of 2 half-cells each. The first half-cell inverts the line. The second half-cell inverts it again for a 1 and holds it for a 0.
- R6: Slot 28 carries the strobed invalid flag (0 = reliable sample). Slot 29 (user) is always 0.
- R7: Slot 30 of both subframes of frame n carries bit n of the channel-status word. That word is 0 everywhere except: bit 2=1, bits 10, 11 and 15 =1 (category 00110001 over bits 8..15), and bits 24 and 25 =1 (rate code 1100 over bits 24..27). Bits 3 and 4 are set by R8.
- R8: Channel-status bits 3 and 4 are both 0 if `deemph_on` is 1 at the start of the frame. They are both 1 if it is 0.
- R9: The line changes only on a half-cell enable, which fires every `DIV_RATIO` clocks (a frame lasts 128 enables). A frame carries the sample held by the most recent strobe before the frame starts. A frame with no new strobe repeats the held sample.
- R10: While reset is low, the line is 0. After reset is released, the first preamble is B, meaning the block restarts at frame 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (DIV_RATIO × 128 × frame rate) |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_strobe | input | 1 | Loads the sample holding registers |
| left_smp | input | SW | Left channel two's-complement sample |
| right_smp | input | SW | Right channel two's-complement sample |
| smp_invalid | input | 1 | 1 marks the strobed sample pair as unreliable |
| deemph_on | input | 1 | 1 = de-emphasis applied; sampled at each frame start |
| line_out | output | 1 | Biphase-mark coded serial line |

## Verification
The bench decodes every half-cell of 200 frames. This spans a block wrap, which catches a design that misplaces preamble B or channel-status bit 0 by one frame or wraps at the wrong count. Each subframe is rebuilt from the requirements and compared at the level of half-cells. A wrong parity polarity would show up as an inverted preamble in the following subframe. A swapped biphase phase would show up as missing cell-boundary transitions.

The stimulus includes full-scale samples of both signs, a single-LSB value and skipped strobes. A design that right-justifies the sample would fail these, and so would one that clears the held sample. A design that latches `deemph_on` at the wrong moment would misreport status bits 3 and 4. A reset in the middle of a frame checks that the block restarts at frame 0, so the first preamble after it must be B, not M.

// File: rtl/cdai_pkg.sv
package cdai_pkg;
  localparam int SLOTS_PER_SUB  = 32;
  localparam int PRE_SLOTS      = 4;
  localparam int AUDIO_SLOTS    = 24;
  localparam int HALF_PER_SUB   = 2 * SLOTS_PER_SUB;
  localparam int HALF_PER_FRAME = 2 * HALF_PER_SUB;
  localparam int HALF_W         = $clog2(HALF_PER_FRAME);
  localparam int SLOT_W         = $clog2(SLOTS_PER_SUB);

  typedef enum logic [1:0] {PRE_B, PRE_M, PRE_W} pre_kind_e;

  // Preamble half-cells for a low preceding level, first-sent bit leftmost.
  function automatic logic [7:0] pre_pattern(input pre_kind_e kind);
    case (kind)
      PRE_B:   return 8'b1110_1000;
      PRE_M:   return 8'b1110_0010;
      default: return 8'b1110_0100;
    endcase
  endfunction

  // One bit of the fixed consumer channel-status word.
  function automatic logic cs_bit(input int unsigned idx, input logic deemph_on);
    localparam logic [7:0] CATEGORY = 8'b0011_0001;  // bits 8..15, bit 8 leftmost
    localparam logic [3:0] RATE     = 4'b1100;       // bits 24..27, bit 24 leftmost
    if (idx == 2)                     return 1'b1;
    else if (idx == 3 || idx == 4)    return ~deemph_on;
    else if (idx >= 8 && idx <= 15)   return CATEGORY[15 - idx];
    else if (idx >= 24 && idx <= 27)  return RATE[27 - idx];
    else                              return 1'b0;
  endfunction
endpackage

// File: rtl/cdai_cell_timer.sv
module cdai_cell_timer
  import cdai_pkg::*;
#(
  parameter int DIV_RATIO    = 2,
  parameter int BLOCK_FRAMES = 192,
  localparam int FW = $clog2(BLOCK_FRAMES),
  localparam int DW = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              cell_en,
  output logic [HALF_W-1:0] half_idx,
  output logic [FW-1:0]     frame_idx,
  output logic              frame_start
);
  logic [HALF_W-1:0] half_q;
  logic [FW-1:0]     frame_q;
  logic              frame_end;

  generate
    if (DIV_RATIO == 1) begin : g_nodiv
      assign cell_en = 1'b1;
    end else begin : g_div
      logic [DW-1:0] div_q;
      always_ff @(posedge clk) begin
        if (!rst_n)                             div_q <= '0;
        else if (div_q == DW'(DIV_RATIO - 1))   div_q <= '0;
        else                                    div_q <= div_q + 1'b1;
      end
      assign cell_en = (div_q == DW'(DIV_RATIO - 1));
    end
  endgenerate

  assign frame_end = (half_q == HALF_W'(HALF_PER_FRAME - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      half_q  <= '0;
      frame_q <= '0;
    end else if (cell_en) begin
      half_q <= frame_end ? '0 : half_q + 1'b1;
      if (frame_end)
        frame_q <= (frame_q == FW'(BLOCK_FRAMES - 1)) ? '0 : frame_q + 1'b1;
    end
  end

  assign half_idx    = half_q;
  assign frame_idx   = frame_q;
  assign frame_start = cell_en && (half_q == '0);
endmodule

// File: rtl/cdai_slot_src.sv
module cdai_slot_src
  import cdai_pkg::*;
#(
  parameter int SW           = 14,
  parameter int BLOCK_FRAMES = 192,
  localparam int FW = $clog2(BLOCK_FRAMES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_strobe,
  input  logic [SW-1:0]     left_smp,
  input  logic [SW-1:0]     right_smp,
  input  logic              smp_invalid,
  input  logic              deemph_on,
  input  logic              frame_start,
  input  logic [HALF_W-1:0] half_idx,
  input  logic [FW-1:0]     frame_idx,
  output logic              pre_active,
  output logic              pre_bit,
  output logic              data_bit
);
  localparam int PAD = AUDIO_SLOTS - SW;
  localparam logic [SLOT_W-1:0] SLOT_A_LO = SLOT_W'(PRE_SLOTS);
  localparam logic [SLOT_W-1:0] SLOT_A_HI = SLOT_W'(PRE_SLOTS + AUDIO_SLOTS - 1);
  localparam logic [SLOT_W-1:0] SLOT_V    = SLOT_W'(PRE_SLOTS + AUDIO_SLOTS);
  localparam logic [SLOT_W-1:0] SLOT_C    = SLOT_W'(PRE_SLOTS + AUDIO_SLOTS + 2);
  localparam logic [SLOT_W-1:0] SLOT_P    = SLOT_W'(PRE_SLOTS + AUDIO_SLOTS + 3);

  logic [SW-1:0] hold_l, hold_r, frm_l, frm_r;
  logic          hold_v, frm_v, frm_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_l <= '0; hold_r <= '0; hold_v <= 1'b0;
    end else if (smp_strobe) begin
      hold_l <= left_smp; hold_r <= right_smp; hold_v <= smp_invalid;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frm_l <= '0; frm_r <= '0; frm_v <= 1'b0; frm_d <= 1'b0;
    end else if (frame_start) begin
      frm_l <= hold_l; frm_r <= hold_r; frm_v <= hold_v; frm_d <= deemph_on;
    end
  end

  logic                   right_sub;
  logic [SLOT_W-1:0]      slot;
  logic [2:0]             pat_idx;
  pre_kind_e              kind;
  logic [7:0]             pat;
  logic [AUDIO_SLOTS-1:0] word;
  logic                   cs_now, par_now;

  assign right_sub = half_idx[HALF_W-1];
  assign slot      = half_idx[HALF_W-2:1];
  assign pat_idx   = {slot[1:0], half_idx[0]};
  assign kind      = right_sub ? PRE_W : ((frame_idx == '0) ? PRE_B : PRE_M);
  assign pat       = pre_pattern(kind);
  assign pre_bit   = pat[3'd7 - pat_idx];
  assign pre_active = (slot < SLOT_A_LO);

  assign word    = {(right_sub ? frm_r : frm_l), {PAD{1'b0}}};
  assign cs_now  = cs_bit({{(32-FW){1'b0}}, frame_idx}, frm_d);
  assign par_now = ^word ^ frm_v ^ cs_now;

  always_comb begin
    if (slot >= SLOT_A_LO && slot <= SLOT_A_HI) data_bit = word[slot - SLOT_A_LO];
    else if (slot == SLOT_V)                    data_bit = frm_v;
    else if (slot == SLOT_C)                    data_bit = cs_now;
    else if (slot == SLOT_P)                    data_bit = par_now;
    else                                        data_bit = 1'b0;
  end
endmodule

// File: rtl/cdai_bmc_line.sv
module cdai_bmc_line
  import cdai_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cell_en,
  input  logic [HALF_W-1:0] half_idx,
  input  logic              pre_active,
  input  logic              pre_bit,
  input  logic              data_bit,
  output logic              line_out
);
  logic line_q, pre_ref, sub_first, ref_lvl, next_lvl;

  assign sub_first = (half_idx[HALF_W-2:0] == '0);
  assign ref_lvl   = sub_first ? line_q : pre_ref;

  always_comb begin
    if (pre_active)        next_lvl = pre_bit ^ ref_lvl;
    else if (!half_idx[0]) next_lvl = ~line_q;
    else                   next_lvl = data_bit ? ~line_q : line_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q  <= 1'b0;
      pre_ref <= 1'b0;
    end else if (cell_en) begin
      line_q <= next_lvl;
      if (sub_first) pre_ref <= line_q;
    end
  end

  assign line_out = line_q;
endmodule

// File: rtl/cdai_tx.sv
module cdai_tx
  import cdai_pkg::*;
#(
  parameter int SW           = 14,
  parameter int DIV_RATIO    = 2,
  parameter int BLOCK_FRAMES = 192
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_strobe,
  input  logic [SW-1:0] left_smp,
  input  logic [SW-1:0] right_smp,
  input  logic          smp_invalid,
  input  logic          deemph_on,
  output logic          line_out
);
  localparam int FW = $clog2(BLOCK_FRAMES);

  logic              cell_en, frame_start, pre_active, pre_bit, data_bit;
  logic [HALF_W-1:0] half_idx;
  logic [FW-1:0]     frame_idx;

  cdai_cell_timer #(.DIV_RATIO(DIV_RATIO), .BLOCK_FRAMES(BLOCK_FRAMES)) timer_i (
    .clk(clk), .rst_n(rst_n), .cell_en(cell_en), .half_idx(half_idx),
    .frame_idx(frame_idx), .frame_start(frame_start)
  );

  cdai_slot_src #(.SW(SW), .BLOCK_FRAMES(BLOCK_FRAMES)) src_i (
    .clk(clk), .rst_n(rst_n), .smp_strobe(smp_strobe), .left_smp(left_smp),
    .right_smp(right_smp), .smp_invalid(smp_invalid), .deemph_on(deemph_on),
    .frame_start(frame_start), .half_idx(half_idx), .frame_idx(frame_idx),
    .pre_active(pre_active), .pre_bit(pre_bit), .data_bit(data_bit)
  );

  cdai_bmc_line line_i (
    .clk(clk), .rst_n(rst_n), .cell_en(cell_en), .half_idx(half_idx),
    .pre_active(pre_active), .pre_bit(pre_bit), .data_bit(data_bit),
    .line_out(line_out)
  );
endmodule

// File: rtl/cdai_tx_chk.sv
module cdai_tx_chk
  import cdai_pkg::*;
#(
  parameter int BLOCK_FRAMES = 192,
  localparam int FW = $clog2(BLOCK_FRAMES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cell_en,
  input logic [HALF_W-1:0] half_idx,
  input logic [FW-1:0]     frame_idx,
  input logic              line_out
);
  // R9
  line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cell_en |=> $stable(line_out));

  // R5
  cell_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_en && half_idx[HALF_W-2:3] != '0 && !half_idx[0]) |=> (line_out != $past(line_out)));

  // R6
  user_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_en && half_idx[HALF_W-2:0] == (HALF_W-1)'(59)) |=> $stable(line_out));

  // R2
  sub_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_en && half_idx[HALF_W-2:0] == '0) |-> (line_out == 1'b0));

  // R4
  pre_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_en && half_idx[HALF_W-2:0] == '0) |=> (line_out != $past(line_out)));

  // R3
  frame_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cell_en |-> (frame_idx < FW'(BLOCK_FRAMES)));
endmodule

bind cdai_tx cdai_tx_chk #(.BLOCK_FRAMES(BLOCK_FRAMES)) chk_i (
  .clk(clk), .rst_n(rst_n), .cell_en(cell_en), .half_idx(half_idx),
  .frame_idx(frame_idx), .line_out(line_out)
);

// File: tb/cdai_tx_tb.sv
module cdai_tx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 14;
  localparam int NFRAMES = 200;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_strobe = 1'b0;
  logic [SW-1:0] left_smp = '0, right_smp = '0;
  logic smp_invalid = 1'b0, deemph_on = 1'b0;
  logic line_out;

  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cdai_tx #(.SW(SW)) dut_i (
    .clk(clk), .rst_n(rst_n), .smp_strobe(smp_strobe), .left_smp(left_smp),
    .right_smp(right_smp), .smp_invalid(smp_invalid), .deemph_on(deemph_on),
    .line_out(line_out)
  );

  // {left, right, invalid, deemph} for frames 1..8
  localparam logic [2*SW+1:0] VEC [8] = '{
    {14'h3FFF, 14'h0000, 1'b0, 1'b0},
    {14'h2000, 14'h1FFF, 1'b1, 1'b0},
    {14'h0001, 14'h2AAA, 1'b0, 1'b1},
    {14'h1555, 14'h0001, 1'b1, 1'b1},
    {14'h0000, 14'h3FFF, 1'b0, 1'b0},
    {14'h1234, 14'h2345, 1'b1, 1'b0},
    {14'h3C3C, 14'h03C3, 1'b0, 1'b1},
    {14'h0F0F, 14'h3001, 1'b0, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit exp_cs(input int idx, input bit de);
    case (idx)
      2:              return 1'b1;
      3, 4:           return !de;
      10, 11, 15:     return 1'b1;
      24, 25:         return 1'b1;
      default:        return 1'b0;
    endcase
  endfunction

  // s[j] is half-cell j of one subframe
  task automatic check_sub(input int f, input bit right, input logic [63:0] s, input bit prev,
                           input logic [SW-1:0] smp, input bit v, input bit de);
    logic [7:0]  pat;
    logic [23:0] word, got_word;
    logic [31:0] bits;
    logic [63:0] e;
    bit lvl, edges_ok, par;
    int idx;
    idx = f % 192;
    if (right)         pat = 8'b11100100;
    else if (idx == 0) pat = 8'b11101000;
    else               pat = 8'b11100010;
    word = {smp, 10'b0};
    bits = '0;
    for (int i = 4; i < 28; i++) bits[i] = word[i-4];
    bits[28] = v; bits[29] = 1'b0; bits[30] = exp_cs(idx, de);
    par = 1'b0;
    for (int i = 4; i < 31; i++) par ^= bits[i];
    bits[31] = par;
    for (int j = 0; j < 8; j++) e[j] = pat[7-j] ^ prev;
    lvl = e[7];
    for (int i = 4; i < 32; i++) begin
      e[2*i] = !lvl;
      e[2*i+1] = bits[i] ? lvl : !lvl;
      lvl = e[2*i+1];
    end
    // R3 R4: preamble kind and polarity
    chk(s[7:0] == e[7:0], (right || idx != 0) ? "R3" : "R4", "preamble", s[7:0], e[7:0]);
    // R5: every data cell starts with a transition
    edges_ok = 1;
    for (int i = 4; i < 32; i++) if (s[2*i] == s[2*i-1]) edges_ok = 0;
    chk(edges_ok, "R5", "cell edge", s, e);
    got_word = '0;
    for (int i = 4; i < 28; i++) got_word[i-4] = s[2*i] ^ s[2*i+1];
    chk(got_word == word, "R1", "audio word", got_word, word);
    chk((s[56] ^ s[57]) == v, "R6", "validity", s[56] ^ s[57], v);
    chk((s[58] ^ s[59]) == 1'b0, "R6", "user", s[58] ^ s[59], 0);
    chk((s[60] ^ s[61]) == bits[30], (idx == 3 || idx == 4) ? "R8" : "R7",
        "status", s[60] ^ s[61], bits[30]);
    par = 1'b0;
    for (int i = 4; i < 32; i++) par ^= s[2*i] ^ s[2*i+1];
    chk(par == 1'b0, "R2", "parity", par, 0);
    chk(s == e, "R9", "subframe", s, e);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [127:0] st;
    logic [SW-1:0] cur_l, cur_r, nx_l, nx_r;
    bit cur_v, cur_d, nx_v, nx_d, prev;
    logic [7:0] pst;

    repeat (4) @(negedge clk);
    // R10: reset level
    chk(line_out == 1'b0, "R10", "reset line", line_out, 0);
    rst_n = 1'b1;
    cur_l = '0; cur_r = '0; cur_v = 0; cur_d = 0;
    nx_l = '0; nx_r = '0; nx_v = 0; nx_d = 0;
    prev = 1'b0;
    for (int f = 0; f < NFRAMES; f++) begin
      bool_skip: begin end
      nx_l = cur_l; nx_r = cur_r; nx_v = cur_v; nx_d = cur_d;
      for (int h = 0; h < 128; h++) begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        st[h] = line_out;
        if (h == 64 && (f % 50) != 49) begin
          if (f < 8) begin
            {nx_l, nx_r, nx_v, nx_d} = VEC[f];
          end else begin
            nx_l = SW'(f * 613 + 7);
            nx_r = SW'(~(f * 151));
            nx_v = f[2];
            nx_d = f[4];
          end
          left_smp = nx_l; right_smp = nx_r; smp_invalid = nx_v; deemph_on = nx_d;
          smp_strobe = 1'b1;
        end
        if (h == 66) smp_strobe = 1'b0;
      end
      check_sub(f, 1'b0, st[63:0], prev, cur_l, cur_v, cur_d);
      check_sub(f, 1'b1, st[127:64], st[63], cur_r, cur_v, cur_d);
      prev = st[127];
      cur_l = nx_l; cur_r = nx_r; cur_v = nx_v; cur_d = nx_d;
    end

    // R10: reset in mid-frame, then the block restarts with preamble B
    repeat (40) @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(line_out == 1'b0, "R10", "mid-run reset line", line_out, 0);
    rst_n = 1'b1;
    for (int h = 0; h < 8; h++) begin
      repeat (2) @(posedge clk);
      @(negedge clk);
      pst[7-h] = line_out;
    end
    chk(pst == 8'b11101000, "R10", "first preamble after reset", pst, 8'hE8);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule